// File: doc/BRIEF.md
# Fetch Target Predictor with Static Fallback

This block predicts the next fetch address for each fetch program counter. Its core is a two-way set-associative table of branch targets, 256 entries in 128 sets. The table is read with the fetch PC in the same cycle. When a valid entry matches, the stored target is the prediction and the fetch is predicted taken.

When nothing matches and predecode flags the instruction as a branch, a static direction rule is used. A negative displacement (a backward branch) is predicted taken. A non-negative displacement (a forward branch) is predicted not taken. A software hint, when it is present, replaces that rule. A taken prediction from the fallback path uses the branch target supplied by predecode. A not-taken prediction, and any non-branch that misses, continues at PC+4.

The table is trained from a resolution port that carries the branch PC, its real target and its outcome. Taken branches are allocated or refreshed. Not-taken branches that hit have their entry removed. One recency bit per set chooses the replacement way.

The block has no state machine. The choice of prediction source is an enumerated selection with five cases: table hit, hint, static backward, static forward and sequential. Their priority is fixed, with a table hit first, then non-branch, then hint, then static rule.

Top module: `fetch_target_predictor`

## Requirements
- R1: After reset every table entry is invalid, so every lookup misses (`pred_hit`=0).
- R2: On a lookup hit, `pred_next_pc` is the stored target and `pred_taken`=1, whatever the branch flag, hint and displacement inputs are.
- R3: On a miss with `lk_is_br`=1 and `lk_hint_vld`=0, `lk_disp_neg`=1 gives `pred_taken`=1 and `pred_next_pc`=`lk_br_target`. `lk_disp_neg`=0 gives `pred_taken`=0 and `pred_next_pc`=`lk_pc`+4.
- R4: On a miss with `lk_is_br`=1 and `lk_hint_vld`=1, `lk_hint_taken` decides the direction regardless of `lk_disp_neg`. Taken means `lk_br_target`; not taken means `lk_pc`+4.
- R5: On a miss with `lk_is_br`=0, `pred_next_pc`=`lk_pc`+4 and `pred_taken`=0.
- R6: A resolved taken branch that misses allocates an entry, which hits from the cycle after the update edge. The set index is PC bits [8:2] and the tag is PC bits [31:9]. PCs that share an index but differ in tag do not hit each other's entries, and neither do PCs that share a tag but differ in index.
- R7: A resolved not-taken branch that hits invalidates its entry. A resolved not-taken branch that misses allocates nothing.
- R8: A resolved taken branch that hits overwrites the stored target with the new one.
- R9: The allocation victim is the first invalid way (way 0 before way 1); if both ways are valid, the recency bit chooses. A lookup hit with `lk_valid`=1 makes the other way the victim. An allocation or refresh makes the other way the victim, and an invalidation makes the freed way the victim. When an update and a lookup touch the same set in one cycle, the update sets the recency bit. Prediction outputs do not depend on `lk_valid`.
- R10: A lookup and an update of the same PC in the same cycle return the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup is a real fetch; a hit updates recency |
| lk_pc | input | 32 | Fetch PC |
| lk_is_br | input | 1 | Predecode marks the instruction as a branch |
| lk_disp_neg | input | 1 | Sign of branch displacement (1 = backward) |
| lk_hint_vld | input | 1 | Software hint present |
| lk_hint_taken | input | 1 | Hinted direction (1 = taken) |
| lk_br_target | input | 32 | Target computed by predecode |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Predicted taken |
| pred_hit | output | 1 | Lookup matched a valid entry |
| up_valid | input | 1 | Resolution update strobe |
| up_pc | input | 32 | PC of the resolved branch |
| up_target | input | 32 | Actual target |
| up_taken | input | 1 | Actual outcome (1 = taken) |

## Verification
The prediction outputs are combinational from the lookup inputs and the stored arrays. The bench therefore drives a lookup just after a falling edge and samples it 1 ns later, in the same cycle and before the next rising edge. An update is held across exactly one rising edge and takes effect at that edge. Its effect is checked by a lookup in the following cycle, once the strobe has dropped. Same-cycle checks of a lookup against a pending update are sampled before that edge, so they must still show the old contents. Recency-changing lookups are given their own cycle with `lk_valid`=1, and probe lookups keep `lk_valid`=0 so that observing the table does not disturb the victim choice.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

    typedef enum logic [2:0] {
        SRC_TABLE  = 3'd0,
        SRC_HINT   = 3'd1,
        SRC_BACK   = 3'd2,
        SRC_FWD    = 3'd3,
        SRC_SEQ    = 3'd4
    } pred_src_e;

    localparam int NUM_WAYS = 2;

endpackage

// File: rtl/ftp_lookup.sv
module ftp_lookup #(
    parameter int TAG_W = 23,
    parameter int PC_W  = 32
) (
    input  logic [1:0][TAG_W-1:0] way_tag,
    input  logic [1:0]            way_vld,
    input  logic [1:0][PC_W-1:0]  way_tgt,
    input  logic [TAG_W-1:0]      tag,
    output logic [1:0]            way_hit,
    output logic                  hit,
    output logic                  hit_way,
    output logic [PC_W-1:0]       hit_tgt
);

    for (genvar w = 0; w < ftp_pkg::NUM_WAYS; w++) begin : g_cmp
        assign way_hit[w] = way_vld[w] && (way_tag[w] == tag);
    end

    assign hit     = |way_hit;
    assign hit_way = way_hit[1];
    assign hit_tgt = way_hit[1] ? way_tgt[1] : way_tgt[0];

endmodule

// File: rtl/ftp_select.sv
module ftp_select
    import ftp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            hit,
    input  logic [PC_W-1:0] hit_tgt,
    input  logic [PC_W-1:0] pc,
    input  logic            is_br,
    input  logic            disp_neg,
    input  logic            hint_vld,
    input  logic            hint_taken,
    input  logic [PC_W-1:0] br_target,
    output logic [PC_W-1:0] next_pc,
    output logic            taken
);

    pred_src_e       src;
    logic [PC_W-1:0] seq_pc;

    assign seq_pc = pc + PC_W'(4);

    // source choice: table first, then non-branch, then hint, then static rule
    always_comb begin
        if (hit)
            src = SRC_TABLE;
        else if (!is_br)
            src = SRC_SEQ;
        else if (hint_vld)
            src = SRC_HINT;
        else if (disp_neg)
            src = SRC_BACK;
        else
            src = SRC_FWD;
    end

    // outputs per source
    always_comb begin
        next_pc = seq_pc;
        taken   = 1'b0;
        unique case (src)
            SRC_TABLE: begin
                next_pc = hit_tgt;
                taken   = 1'b1;
            end
            SRC_HINT: begin
                taken   = hint_taken;
                next_pc = hint_taken ? br_target : seq_pc;
            end
            SRC_BACK: begin
                next_pc = br_target;
                taken   = 1'b1;
            end
            SRC_FWD: begin
                next_pc = seq_pc;
                taken   = 1'b0;
            end
            SRC_SEQ: begin
                next_pc = seq_pc;
                taken   = 1'b0;
            end
            default: begin
                next_pc = seq_pc;
                taken   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ftp_store.sv
module ftp_store #(
    parameter int PC_W  = 32,
    parameter int SETS  = 128,
    parameter int IDX_W = 7,
    parameter int TAG_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    // lookup read port
    input  logic [IDX_W-1:0]      lk_idx,
    output logic [1:0][TAG_W-1:0] lk_tag_rd,
    output logic [1:0]            lk_vld_rd,
    output logic [1:0][PC_W-1:0]  lk_tgt_rd,
    input  logic                  lk_touch,
    input  logic                  lk_hit_way,
    // update read port
    input  logic [IDX_W-1:0]      up_idx,
    output logic [1:0][TAG_W-1:0] up_tag_rd,
    output logic [1:0]            up_vld_rd,
    output logic [1:0][PC_W-1:0]  up_tgt_rd,
    // update command
    input  logic                  up_valid,
    input  logic                  up_taken,
    input  logic [TAG_W-1:0]      up_tag,
    input  logic [PC_W-1:0]       up_target,
    input  logic                  up_hit,
    input  logic                  up_hit_way
);

    logic [TAG_W-1:0] tag_q [2][SETS];
    logic [PC_W-1:0]  tgt_q [2][SETS];
    logic [SETS-1:0]  vld_q [2];
    logic [SETS-1:0]  lru_q;

    // read ports
    for (genvar w = 0; w < ftp_pkg::NUM_WAYS; w++) begin : g_rd
        assign lk_tag_rd[w] = tag_q[w][lk_idx];
        assign lk_vld_rd[w] = vld_q[w][lk_idx];
        assign lk_tgt_rd[w] = tgt_q[w][lk_idx];
        assign up_tag_rd[w] = tag_q[w][up_idx];
        assign up_vld_rd[w] = vld_q[w][up_idx];
        assign up_tgt_rd[w] = tgt_q[w][up_idx];
    end

    // update decision
    logic wr_data_en;
    logic wr_vld_en;
    logic wr_vld_val;
    logic wr_way;
    logic victim;
    logic up_lru_we;
    logic up_lru_val;

    always_comb begin
        if (!up_vld_rd[0])
            victim = 1'b0;
        else if (!up_vld_rd[1])
            victim = 1'b1;
        else
            victim = lru_q[up_idx];
    end

    always_comb begin
        wr_data_en = 1'b0;
        wr_vld_en  = 1'b0;
        wr_vld_val = 1'b0;
        wr_way     = 1'b0;
        up_lru_we  = 1'b0;
        up_lru_val = 1'b0;
        if (up_valid) begin
            if (up_hit && up_taken) begin
                wr_data_en = 1'b1;
                wr_vld_en  = 1'b1;
                wr_vld_val = 1'b1;
                wr_way     = up_hit_way;
                up_lru_we  = 1'b1;
                up_lru_val = ~up_hit_way;
            end else if (up_hit) begin
                wr_vld_en  = 1'b1;
                wr_vld_val = 1'b0;
                wr_way     = up_hit_way;
                up_lru_we  = 1'b1;
                up_lru_val = up_hit_way;
            end else if (up_taken) begin
                wr_data_en = 1'b1;
                wr_vld_en  = 1'b1;
                wr_vld_val = 1'b1;
                wr_way     = victim;
                up_lru_we  = 1'b1;
                up_lru_val = ~victim;
            end
        end
    end

    logic lk_lru_we;
    assign lk_lru_we = lk_touch && !(up_lru_we && (up_idx == lk_idx));

    // valid and recency state, reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q[0] <= '0;
            vld_q[1] <= '0;
            lru_q    <= '0;
        end else begin
            if (wr_vld_en)
                vld_q[wr_way][up_idx] <= wr_vld_val;
            if (up_lru_we)
                lru_q[up_idx] <= up_lru_val;
            if (lk_lru_we)
                lru_q[lk_idx] <= ~lk_hit_way;
        end
    end

    // tag and target arrays, no reset
    always_ff @(posedge clk) begin
        if (wr_data_en) begin
            tag_q[wr_way][up_idx] <= up_tag;
            tgt_q[wr_way][up_idx] <= up_target;
        end
    end

endmodule

// File: rtl/fetch_target_predictor.sv
module fetch_target_predictor #(
    parameter int PC_W       = 32,
    parameter int ENTRIES    = 256,
    parameter int ALIGN_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_is_br,
    input  logic            lk_disp_neg,
    input  logic            lk_hint_vld,
    input  logic            lk_hint_taken,
    input  logic [PC_W-1:0] lk_br_target,
    output logic [PC_W-1:0] pred_next_pc,
    output logic            pred_taken,
    output logic            pred_hit,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic [PC_W-1:0] up_target,
    input  logic            up_taken
);

    localparam int SETS  = ENTRIES / ftp_pkg::NUM_WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_LO = ALIGN_BITS + IDX_W;
    localparam int TAG_W = PC_W - TAG_LO;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;

    assign lk_idx = lk_pc[TAG_LO-1:ALIGN_BITS];
    assign lk_tag = lk_pc[PC_W-1:TAG_LO];
    assign up_idx = up_pc[TAG_LO-1:ALIGN_BITS];
    assign up_tag = up_pc[PC_W-1:TAG_LO];

    logic unused_up_low;
    assign unused_up_low = ^up_pc[ALIGN_BITS-1:0];

    logic [1:0][TAG_W-1:0] lk_tag_rd, up_tag_rd;
    logic [1:0]            lk_vld_rd, up_vld_rd;
    logic [1:0][PC_W-1:0]  lk_tgt_rd, up_tgt_rd;

    logic [1:0]      lk_way_hit, up_way_hit;
    logic            lk_hit, up_hit;
    logic            lk_hit_way, up_hit_way;
    logic [PC_W-1:0] lk_hit_tgt, up_hit_tgt;

    logic unused_up_read;
    assign unused_up_read = ^{up_hit_tgt, up_way_hit};

    ftp_store #(
        .PC_W (PC_W),
        .SETS (SETS),
        .IDX_W(IDX_W),
        .TAG_W(TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .lk_tag_rd (lk_tag_rd),
        .lk_vld_rd (lk_vld_rd),
        .lk_tgt_rd (lk_tgt_rd),
        .lk_touch  (lk_valid && lk_hit),
        .lk_hit_way(lk_hit_way),
        .up_idx    (up_idx),
        .up_tag_rd (up_tag_rd),
        .up_vld_rd (up_vld_rd),
        .up_tgt_rd (up_tgt_rd),
        .up_valid  (up_valid),
        .up_taken  (up_taken),
        .up_tag    (up_tag),
        .up_target (up_target),
        .up_hit    (up_hit),
        .up_hit_way(up_hit_way)
    );

    ftp_lookup #(.TAG_W(TAG_W), .PC_W(PC_W)) u_lk_cmp (
        .way_tag(lk_tag_rd),
        .way_vld(lk_vld_rd),
        .way_tgt(lk_tgt_rd),
        .tag    (lk_tag),
        .way_hit(lk_way_hit),
        .hit    (lk_hit),
        .hit_way(lk_hit_way),
        .hit_tgt(lk_hit_tgt)
    );

    ftp_lookup #(.TAG_W(TAG_W), .PC_W(PC_W)) u_up_cmp (
        .way_tag(up_tag_rd),
        .way_vld(up_vld_rd),
        .way_tgt(up_tgt_rd),
        .tag    (up_tag),
        .way_hit(up_way_hit),
        .hit    (up_hit),
        .hit_way(up_hit_way),
        .hit_tgt(up_hit_tgt)
    );

    ftp_select #(.PC_W(PC_W)) u_sel (
        .hit       (lk_hit),
        .hit_tgt   (lk_hit_tgt),
        .pc        (lk_pc),
        .is_br     (lk_is_br),
        .disp_neg  (lk_disp_neg),
        .hint_vld  (lk_hint_vld),
        .hint_taken(lk_hint_taken),
        .br_target (lk_br_target),
        .next_pc   (pred_next_pc),
        .taken     (pred_taken)
    );

    assign pred_hit = lk_hit;

endmodule

// File: rtl/ftp_chk.sv
module ftp_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_is_br,
    input logic            lk_hint_vld,
    input logic            lk_hint_taken,
    input logic [PC_W-1:0] lk_br_target,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            pred_taken,
    input logic            pred_hit,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic [PC_W-1:0] up_target,
    input logic            up_taken,
    input logic [1:0]      lk_way_hit
);

    // R2
    hit_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> pred_taken);

    // R5
    seq_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_hit && !lk_is_br) |-> (!pred_taken && pred_next_pc == lk_pc + PC_W'(4)));

    // R4
    hint_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_hit && lk_is_br && lk_hint_vld) |->
            (pred_taken == lk_hint_taken &&
             pred_next_pc == (lk_hint_taken ? lk_br_target : lk_pc + PC_W'(4))));

    // R6
    no_dup_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_way_hit));

    // R6
    alloc_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_valid && up_taken) && lk_pc == $past(up_pc)) |->
            (pred_hit && pred_next_pc == $past(up_target)));

    // R7
    drop_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_valid && !up_taken) && lk_pc == $past(up_pc)) |-> !pred_hit);

endmodule

bind fetch_target_predictor ftp_chk #(.PC_W(PC_W)) u_ftp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_pc        (lk_pc),
    .lk_is_br     (lk_is_br),
    .lk_hint_vld  (lk_hint_vld),
    .lk_hint_taken(lk_hint_taken),
    .lk_br_target (lk_br_target),
    .pred_next_pc (pred_next_pc),
    .pred_taken   (pred_taken),
    .pred_hit     (pred_hit),
    .up_valid     (up_valid),
    .up_pc        (up_pc),
    .up_target    (up_target),
    .up_taken     (up_taken),
    .lk_way_hit   (lk_way_hit)
);

// File: tb/test_fetch_target_predictor.sv
module test_fetch_target_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_is_br = 1'b0;
    logic        lk_disp_neg = 1'b0;
    logic        lk_hint_vld = 1'b0;
    logic        lk_hint_taken = 1'b0;
    logic [31:0] lk_br_target = '0;
    logic [31:0] pred_next_pc;
    logic        pred_taken;
    logic        pred_hit;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_target = '0;
    logic        up_taken = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    fetch_target_predictor i_fetch_target_predictor (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_is_br(lk_is_br), .lk_disp_neg(lk_disp_neg),
        .lk_hint_vld(lk_hint_vld), .lk_hint_taken(lk_hint_taken),
        .lk_br_target(lk_br_target), .pred_next_pc(pred_next_pc),
        .pred_taken(pred_taken), .pred_hit(pred_hit),
        .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
        .up_taken(up_taken)
    );

    function automatic logic [31:0] mk(input logic [22:0] tag, input logic [6:0] idx);
        return {tag, idx, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] e_pc, input logic e_tk, input logic e_hit);
        #1;
        n_chk++;
        if (pred_next_pc !== e_pc || pred_taken !== e_tk || pred_hit !== e_hit) begin
            n_err++;
            $display("FAIL %s: next=%h taken=%b hit=%b expected next=%h taken=%b hit=%b",
                     req, pred_next_pc, pred_taken, pred_hit, e_pc, e_tk, e_hit);
        end
    endtask

    task automatic probe(input string req, input logic [31:0] pc, input logic br,
                         input logic neg, input logic hv, input logic ht,
                         input logic [31:0] bt, input logic [31:0] e_pc,
                         input logic e_tk, input logic e_hit);
        lk_valid = 1'b0; lk_pc = pc; lk_is_br = br; lk_disp_neg = neg;
        lk_hint_vld = hv; lk_hint_taken = ht; lk_br_target = bt;
        chk(req, e_pc, e_tk, e_hit);
    endtask

    task automatic do_update(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_target = tgt; up_taken = tk;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic touch(input logic [31:0] pc);
        @(negedge clk);
        lk_pc = pc; lk_valid = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        probe("R1", mk(23'h0, 7'h0), 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h4, 1'b0, 1'b0);
        probe("R1", mk(23'h7fffff, 7'h7f), 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,
              mk(23'h7fffff, 7'h7f) + 32'd4, 1'b0, 1'b0);
        probe("R5", 32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b1, 32'h5000, 32'h0000_1004, 1'b0, 1'b0);
    endtask

    task automatic t_static;
        @(negedge clk);
        probe("R3 backward", 32'h0000_2000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1f00,
              32'h0000_1f00, 1'b1, 1'b0);
        probe("R3 forward", 32'h0000_2000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2100,
              32'h0000_2004, 1'b0, 1'b0);
    endtask

    task automatic t_hint;
        @(negedge clk);
        probe("R4 hint not-taken on backward", 32'h0000_3000, 1'b1, 1'b1, 1'b1, 1'b0,
              32'h0000_2f00, 32'h0000_3004, 1'b0, 1'b0);
        probe("R4 hint taken on forward", 32'h0000_3000, 1'b1, 1'b0, 1'b1, 1'b1,
              32'h0000_3100, 32'h0000_3100, 1'b1, 1'b0);
    endtask

    task automatic t_alloc;
        logic [31:0] p;
        p = mk(23'h00012, 7'h03);
        do_update(p, 32'h0000_8000, 1'b1);
        probe("R6 alloc hit", p, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_8000, 1'b1, 1'b1);
        probe("R2 hit beats forward rule", p, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_9999,
              32'h0000_8000, 1'b1, 1'b1);
        probe("R6 other tag same set", mk(23'h00013, 7'h03), 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,
              mk(23'h00013, 7'h03) + 32'd4, 1'b0, 1'b0);
        probe("R6 same tag other set", mk(23'h00012, 7'h04), 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,
              mk(23'h00012, 7'h04) + 32'd4, 1'b0, 1'b0);
    endtask

    task automatic t_refresh;
        logic [31:0] p;
        p = mk(23'h00012, 7'h03);
        do_update(p, 32'h0000_a000, 1'b1);
        probe("R8 refresh", p, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_a000, 1'b1, 1'b1);
    endtask

    task automatic t_inval;
        logic [31:0] p, q;
        p = mk(23'h00012, 7'h03);
        q = mk(23'h00055, 7'h10);
        do_update(p, 32'h0, 1'b0);
        probe("R7 invalidated", p, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, p + 32'd4, 1'b0, 1'b0);
        do_update(q, 32'h0000_c000, 1'b0);
        probe("R7 not-taken miss no alloc", q, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, q + 32'd4, 1'b0, 1'b0);
    endtask

    task automatic t_victim;
        logic [31:0] a, b, c;
        a = mk(23'h00100, 7'h05);
        b = mk(23'h00200, 7'h05);
        c = mk(23'h00300, 7'h05);
        do_update(a, 32'h0001_0000, 1'b1);
        do_update(b, 32'h0002_0000, 1'b1);
        touch(a);
        do_update(c, 32'h0003_0000, 1'b1);
        probe("R9 touched way kept", a, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0001_0000, 1'b1, 1'b1);
        probe("R9 lru way evicted", b, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, b + 32'd4, 1'b0, 1'b0);
        probe("R9 new entry", c, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0003_0000, 1'b1, 1'b1);
        a = mk(23'h00100, 7'h06);
        b = mk(23'h00200, 7'h06);
        c = mk(23'h00300, 7'h06);
        do_update(a, 32'h0004_0000, 1'b1);
        do_update(b, 32'h0005_0000, 1'b1);
        do_update(c, 32'h0006_0000, 1'b1);
        probe("R9 oldest evicted", a, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, a + 32'd4, 1'b0, 1'b0);
        probe("R9 recent kept", b, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0005_0000, 1'b1, 1'b1);
    endtask

    task automatic t_same_cycle;
        logic [31:0] p;
        p = mk(23'h00444, 7'h09);
        @(negedge clk);
        up_valid = 1'b1; up_pc = p; up_target = 32'h0007_0000; up_taken = 1'b1;
        probe("R10 pre-update view", p, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, p + 32'd4, 1'b0, 1'b0);
        @(negedge clk);
        up_valid = 1'b0;
        probe("R10 post-update view", p, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0007_0000, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_static();
        t_hint();
        t_alloc();
        t_refresh();
        t_inval();
        t_victim();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule